// File: doc/BRIEF.md
# Cipher Accelerator Control and Status Register File

This block is the register-side front end of a block-cipher accelerator. It sits on a simple 32-bit word-addressed register bus and holds the control word, a status word, eight key words and four initialization-vector words. The cipher engine itself sits elsewhere. It receives the configuration and key material on dedicated output ports and talks back through a start pulse, a done pulse, a busy level, two error event strobes and a derived-key bus.

While the unit is enabled, the block protects the configuration that the engine depends on. Writes to the cipher configuration fields take effect only when the unit is disabled, or when the same write also clears the enable. Key and IV writes are dropped while the unit is enabled. Mode selections that cannot work are resolved in hardware. The block keeps sticky completion and error flags that software clears by writing one to a clear bit. A single interrupt output combines the flags with their enables. After a key-preparation run, the enable bit clears itself. After a decryption run, key reads return the key that the engine derived.

Top module: `cipher_csr`

## Requirements
- R1: After reset, the control and status words read 0, `irq`, `core_start` and `unit_en` are 0, and all key and IV outputs are 0.
- R2: The control word (word address 0) places its fields as follows: enable at bit 0, data format at [2:1], operation mode at [4:3], chaining select at {16,[6:5]}, done-clear at 7, error-clear at 8, done interrupt enable at 9, error interrupt enable at 10, input and output DMA enables at 11 and 12, AEAD phase at [14:13], key size at 18 and padding count at [23:20]. Bits 7 and 8, and all other bits, read as 0.
- R3: A control write that finds enable at 1 and keeps bit 0 at 1 leaves data format, mode, chaining and key size unchanged. A write with bit 0 at 0, or any write while disabled, updates them.
- R4: When a permitted write requests mode 2'b11 (key preparation followed by one decryption) with a chaining select other than 3'b000 or 3'b001, the stored mode becomes 2'b10 (decrypt).
- R5: When the stored mode is 2'b11, a permitted write that would result in 2'b10 keeps the mode at 2'b11.
- R6: A `core_done` pulse received while the unit is enabled in mode 2'b01 (key preparation) clears enable and sets the done flag.
- R7: The status word (word address 1) shows the done flag at bit 0, the read error at bit 1, the write error at bit 2 and `core_busy` at bit 3. `core_done`, `core_rd_err` and `core_wr_err` set the three flags, and the flags stay set until they are cleared.
- R8: Writing 1 to control bit 7 clears the done flag. Writing 1 to bit 8 clears both error flags. If a set event and a clear arrive in the same cycle, the set wins.
- R9: `irq` = (done flag AND bit 9) OR ((read error OR write error) AND bit 10).
- R10: Key words 0 to 7 are at word addresses 2 to 9, with word 0 driving `key_out[31:0]`. IV words 0 to 3 are at addresses 10 to 13. Writes to these addresses while enabled are dropped.
- R11: With key size 0, `key_out[255:128]` reads 0 and the lower half carries words 0 to 3. With key size 1, all eight words are driven.
- R12: Key reads return the written words until a `core_done` is received while the unit is enabled in mode 2'b10. From then on they return the matching word of `derived_key`, until the next key write or enable rise.
- R13: `core_start` pulses for one cycle when enable rises, and when `blk_last` is seen while the unit is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on the read strobe |
| blk_last | input | 1 | Last input word of a block accepted by the data path |
| core_done | input | 1 | Engine completion pulse |
| core_busy | input | 1 | Engine busy level |
| core_rd_err | input | 1 | Unexpected output read event |
| core_wr_err | input | 1 | Unexpected input write event |
| derived_key | input | 256 | Decryption key produced by the engine |
| core_start | output | 1 | Start pulse to the engine |
| unit_en | output | 1 | Current enable |
| cfg_mode | output | 2 | Effective operation mode |
| cfg_chain | output | 3 | Chaining select |
| cfg_dtype | output | 2 | Data format |
| cfg_keysize | output | 1 | Key size, 0 = 128-bit, 1 = 256-bit |
| cfg_phase | output | 2 | AEAD phase |
| cfg_pad | output | 4 | Padding byte count |
| dma_in_en | output | 1 | Input DMA enable |
| dma_out_en | output | 1 | Output DMA enable |
| key_out | output | 256 | Key to the engine |
| iv_out | output | 128 | IV to the engine |
| irq | output | 1 | Combined interrupt |

## Verification
Register state (configuration, flags, keys, enable) changes on the clock edge that samples the write or event strobe. Outputs derived from it, such as `irq`, `key_out`, `unit_en` and `core_start`, are valid one cycle after the stimulus is presented. `bus_rdata` is captured on the edge that samples `bus_rd`. The bench drives every strobe for exactly one cycle starting at a falling edge and compares results at the next falling edge. That lands halfway after the edge that carries the effect. `core_start` is also checked one cycle later, to confirm the pulse is a single cycle wide.

// File: rtl/cipher_csr_pkg.sv
package cipher_csr_pkg;

  localparam int CW_EN      = 0;
  localparam int CW_DT_LSB  = 1;
  localparam int CW_MD_LSB  = 3;
  localparam int CW_CHL_LSB = 5;
  localparam int CW_DCLR    = 7;
  localparam int CW_ECLR    = 8;
  localparam int CW_DIE     = 9;
  localparam int CW_EIE     = 10;
  localparam int CW_DMI     = 11;
  localparam int CW_DMO     = 12;
  localparam int CW_PH_LSB  = 13;
  localparam int CW_CHH     = 16;
  localparam int CW_KS      = 18;
  localparam int CW_PAD_LSB = 20;

  localparam int IDX_CTRL     = 0;
  localparam int IDX_STAT     = 1;
  localparam int IDX_KEY_BASE = 2;

  typedef enum logic [1:0] {
    OP_ENCRYPT   = 2'b00,
    OP_KEYPREP   = 2'b01,
    OP_DECRYPT   = 2'b10,
    OP_PREP_DEC  = 2'b11
  } op_mode_e;

  typedef struct packed {
    logic [3:0] pad;
    logic       keysize;
    logic [2:0] chain;
    logic [1:0] phase;
    logic       dma_out;
    logic       dma_in;
    logic       err_ie;
    logic       done_ie;
    op_mode_e   mode;
    logic [1:0] dtype;
    logic       en;
  } ctrl_t;

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    logic [31:0] w;
    w                   = '0;
    w[CW_EN]            = c.en;
    w[CW_DT_LSB +: 2]   = c.dtype;
    w[CW_MD_LSB +: 2]   = c.mode;
    w[CW_CHL_LSB +: 2]  = c.chain[1:0];
    w[CW_CHH]           = c.chain[2];
    w[CW_DIE]           = c.done_ie;
    w[CW_EIE]           = c.err_ie;
    w[CW_DMI]           = c.dma_in;
    w[CW_DMO]           = c.dma_out;
    w[CW_PH_LSB +: 2]   = c.phase;
    w[CW_KS]            = c.keysize;
    w[CW_PAD_LSB +: 4]  = c.pad;
    return w;
  endfunction

endpackage

// File: rtl/cipher_csr_ctrl.sv
module cipher_csr_ctrl
  import cipher_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic [31:0] wdata,
  input  logic        hw_en_clr,
  output ctrl_t       ctrl_q,
  output logic        en_next
);

  ctrl_t      ctrl_n;
  logic       cfg_open;
  op_mode_e   cand_mode;
  logic [2:0] cand_chain;
  logic       unused_wbits;

  assign unused_wbits = ^{wdata[31:24], wdata[19], wdata[17], wdata[15],
                          wdata[CW_ECLR], wdata[CW_DCLR]};

  // next-state: configuration fields open only when disabled or being disabled
  always_comb begin
    ctrl_n     = ctrl_q;
    cfg_open   = !ctrl_q.en || !wdata[CW_EN];
    cand_chain = {wdata[CW_CHH], wdata[CW_CHL_LSB +: 2]};
    cand_mode  = op_mode_e'(wdata[CW_MD_LSB +: 2]);
    // R4: single-block decrypt only with ECB/CBC chaining
    if (cand_mode == OP_PREP_DEC && cand_chain > 3'd1) begin
      cand_mode = OP_DECRYPT;
    end
    // R5: no step from prepare-and-decrypt back to plain decrypt
    if (ctrl_q.mode == OP_PREP_DEC && cand_mode == OP_DECRYPT) begin
      cand_mode = OP_PREP_DEC;
    end
    if (wr_ctrl) begin
      ctrl_n.en      = wdata[CW_EN];
      ctrl_n.done_ie = wdata[CW_DIE];
      ctrl_n.err_ie  = wdata[CW_EIE];
      ctrl_n.dma_in  = wdata[CW_DMI];
      ctrl_n.dma_out = wdata[CW_DMO];
      ctrl_n.phase   = wdata[CW_PH_LSB +: 2];
      ctrl_n.pad     = wdata[CW_PAD_LSB +: 4];
      if (cfg_open) begin
        ctrl_n.dtype   = wdata[CW_DT_LSB +: 2];
        ctrl_n.mode    = cand_mode;
        ctrl_n.chain   = cand_chain;
        ctrl_n.keysize = wdata[CW_KS];
      end
    end
    // R6: key preparation completion drops enable
    if (hw_en_clr) begin
      ctrl_n.en = 1'b0;
    end
  end

  assign en_next = ctrl_n.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
    end
  end

endmodule

// File: rtl/cipher_csr_flags.sv
module cipher_csr_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_evt,
  input  logic       rd_err_evt,
  input  logic       wr_err_evt,
  input  logic       clr_done,
  input  logic       clr_err,
  input  logic       busy,
  input  logic       done_ie,
  input  logic       err_ie,
  output logic [3:0] status,
  output logic       irq
);

  logic done_q, rderr_q, wrerr_q;
  logic done_n, rderr_n, wrerr_n;

  // set has priority over clear
  always_comb begin
    done_n  = done_evt   | (done_q  & ~clr_done);
    rderr_n = rd_err_evt | (rderr_q & ~clr_err);
    wrerr_n = wr_err_evt | (wrerr_q & ~clr_err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      rderr_q <= 1'b0;
      wrerr_q <= 1'b0;
    end else begin
      done_q  <= done_n;
      rderr_q <= rderr_n;
      wrerr_q <= wrerr_n;
    end
  end

  assign status = {busy, wrerr_q, rderr_q, done_q};
  assign irq    = (done_q & done_ie) | ((rderr_q | wrerr_q) & err_ie);

endmodule

// File: rtl/cipher_csr_keyiv.sv
module cipher_csr_keyiv #(
  parameter int DATA_W    = 32,
  parameter int KEY_WORDS = 8,
  parameter int IV_WORDS  = 4,
  parameter int ADDR_W    = 4,
  parameter int KEY_BASE  = 2,
  localparam int KEY_W    = DATA_W * KEY_WORDS,
  localparam int IV_W     = DATA_W * IV_WORDS,
  localparam int IV_BASE  = KEY_BASE + KEY_WORDS,
  localparam int HALF     = KEY_WORDS / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [KEY_WORDS-1:0] key_we,
  input  logic [IV_WORDS-1:0]  iv_we,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 keysize,
  input  logic                 derived_sel,
  input  logic [KEY_W-1:0]     derived_key,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic                 rd_hit,
  output logic [DATA_W-1:0]    rd_data,
  output logic [KEY_W-1:0]     key_out,
  output logic [IV_W-1:0]      iv_out
);

  logic [DATA_W-1:0] key_q [KEY_WORDS];
  logic [DATA_W-1:0] iv_q  [IV_WORDS];

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        key_q[g] <= '0;
      end else if (key_we[g]) begin
        key_q[g] <= wdata;
      end
    end
    if (g >= HALF) begin : g_upper
      assign key_out[g*DATA_W +: DATA_W] = keysize ? key_q[g] : '0;
    end else begin : g_lower
      assign key_out[g*DATA_W +: DATA_W] = key_q[g];
    end
  end

  for (genvar g = 0; g < IV_WORDS; g++) begin : g_iv
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        iv_q[g] <= '0;
      end else if (iv_we[g]) begin
        iv_q[g] <= wdata;
      end
    end
    assign iv_out[g*DATA_W +: DATA_W] = iv_q[g];
  end

  always_comb begin
    rd_hit  = 1'b0;
    rd_data = '0;
    for (int i = 0; i < KEY_WORDS; i++) begin
      if (rd_addr == ADDR_W'(KEY_BASE + i)) begin
        rd_hit  = 1'b1;
        rd_data = derived_sel ? derived_key[i*DATA_W +: DATA_W] : key_q[i];
      end
    end
    for (int i = 0; i < IV_WORDS; i++) begin
      if (rd_addr == ADDR_W'(IV_BASE + i)) begin
        rd_hit  = 1'b1;
        rd_data = iv_q[i];
      end
    end
  end

endmodule

// File: rtl/cipher_csr.sv
module cipher_csr
  import cipher_csr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int KEY_WORDS = 8,
  parameter int IV_WORDS  = 4,
  parameter int ADDR_W    = 4,
  localparam int KEY_W    = DATA_W * KEY_WORDS,
  localparam int IV_W     = DATA_W * IV_WORDS,
  localparam int IV_BASE  = IDX_KEY_BASE + KEY_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              blk_last,
  input  logic              core_done,
  input  logic              core_busy,
  input  logic              core_rd_err,
  input  logic              core_wr_err,
  input  logic [KEY_W-1:0]  derived_key,
  output logic              core_start,
  output logic              unit_en,
  output logic [1:0]        cfg_mode,
  output logic [2:0]        cfg_chain,
  output logic [1:0]        cfg_dtype,
  output logic              cfg_keysize,
  output logic [1:0]        cfg_phase,
  output logic [3:0]        cfg_pad,
  output logic              dma_in_en,
  output logic              dma_out_en,
  output logic [KEY_W-1:0]  key_out,
  output logic [IV_W-1:0]   iv_out,
  output logic              irq
);

  ctrl_t                ctrl_q;
  logic                 en_next;
  logic                 wr_ctrl;
  logic                 hw_en_clr;
  logic [3:0]           stat_w;
  logic [KEY_WORDS-1:0] key_we;
  logic [IV_WORDS-1:0]  iv_we;
  logic                 kv_hit;
  logic [DATA_W-1:0]    kv_data;
  logic                 dview_q, dview_n;
  logic                 start_q, start_n;
  logic [31:0]          rdata_q, rd_mux;

  assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(IDX_CTRL));
  assign hw_en_clr = core_done && ctrl_q.en && (ctrl_q.mode == OP_KEYPREP);

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_kdec
    assign key_we[g] = bus_wr && !ctrl_q.en && (bus_addr == ADDR_W'(IDX_KEY_BASE + g));
  end
  for (genvar g = 0; g < IV_WORDS; g++) begin : g_idec
    assign iv_we[g] = bus_wr && !ctrl_q.en && (bus_addr == ADDR_W'(IV_BASE + g));
  end

  cipher_csr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .wdata     (bus_wdata),
    .hw_en_clr (hw_en_clr),
    .ctrl_q    (ctrl_q),
    .en_next   (en_next)
  );

  cipher_csr_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_evt   (core_done),
    .rd_err_evt (core_rd_err),
    .wr_err_evt (core_wr_err),
    .clr_done   (wr_ctrl && bus_wdata[CW_DCLR]),
    .clr_err    (wr_ctrl && bus_wdata[CW_ECLR]),
    .busy       (core_busy),
    .done_ie    (ctrl_q.done_ie),
    .err_ie     (ctrl_q.err_ie),
    .status     (stat_w),
    .irq        (irq)
  );

  cipher_csr_keyiv #(
    .DATA_W    (DATA_W),
    .KEY_WORDS (KEY_WORDS),
    .IV_WORDS  (IV_WORDS),
    .ADDR_W    (ADDR_W),
    .KEY_BASE  (IDX_KEY_BASE)
  ) u_keyiv (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_we      (key_we),
    .iv_we       (iv_we),
    .wdata       (bus_wdata[DATA_W-1:0]),
    .keysize     (ctrl_q.keysize),
    .derived_sel (dview_q),
    .derived_key (derived_key),
    .rd_addr     (bus_addr),
    .rd_hit      (kv_hit),
    .rd_data     (kv_data),
    .key_out     (key_out),
    .iv_out      (iv_out)
  );

  // derived-key view and start pulse, next state
  always_comb begin
    dview_n = dview_q;
    if ((en_next && !ctrl_q.en) || (|key_we)) begin
      dview_n = 1'b0;
    end else if (core_done && ctrl_q.en && ctrl_q.mode == OP_DECRYPT) begin
      dview_n = 1'b1;
    end
    start_n = (en_next && !ctrl_q.en) || (blk_last && ctrl_q.en);
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(IDX_CTRL)) begin
      rd_mux = ctrl_to_word(ctrl_q);
    end else if (bus_addr == ADDR_W'(IDX_STAT)) begin
      rd_mux = {28'd0, stat_w};
    end else if (kv_hit) begin
      rd_mux = 32'(kv_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dview_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      dview_q <= dview_n;
      start_q <= start_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata   = rdata_q;
  assign core_start  = start_q;
  assign unit_en     = ctrl_q.en;
  assign cfg_mode    = ctrl_q.mode;
  assign cfg_chain   = ctrl_q.chain;
  assign cfg_dtype   = ctrl_q.dtype;
  assign cfg_keysize = ctrl_q.keysize;
  assign cfg_phase   = ctrl_q.phase;
  assign cfg_pad     = ctrl_q.pad;
  assign dma_in_en   = ctrl_q.dma_in;
  assign dma_out_en  = ctrl_q.dma_out;

endmodule

// File: rtl/cipher_csr_chk.sv
module cipher_csr_chk #(
  parameter int ADDR_W    = 4,
  parameter int KEY_WORDS = 8,
  parameter int KEY_W     = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              core_done,
  input logic              core_start,
  input logic              unit_en,
  input logic [1:0]        cfg_mode,
  input logic [2:0]        cfg_chain,
  input logic [1:0]        cfg_dtype,
  input logic              cfg_keysize,
  input logic [KEY_W-1:0]  key_out,
  input logic [3:0]        stat
);

  logic ctl_wr;
  logic key_wr;
  assign ctl_wr = bus_wr && (bus_addr == '0);
  assign key_wr = bus_wr && (bus_addr >= ADDR_W'(2)) && (bus_addr < ADDR_W'(2 + KEY_WORDS));

  a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && unit_en && bus_wdata[0]) |=>
      ($stable(cfg_mode) && $stable(cfg_chain) && $stable(cfg_dtype) && $stable(cfg_keysize)));

  a_r4_remap_decrypt: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && (!unit_en || !bus_wdata[0]) && bus_wdata[4:3] == 2'b11 &&
     {bus_wdata[16], bus_wdata[6:5]} > 3'd1 && cfg_mode != 2'b11) |=> (cfg_mode == 2'b10));

  a_r5_no_back_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b11) |=> (cfg_mode != 2'b10));

  a_r6_prep_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && unit_en && cfg_mode == 2'b01) |=> (!unit_en && stat[0]));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !(ctl_wr && bus_wdata[7])) |=> stat[0]);

  a_r8_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[7] && !core_done) |=> !stat[0]);

  a_r10_key_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && unit_en) |=> $stable(key_out));

  a_r13_start_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unit_en) |-> core_start);

endmodule

bind cipher_csr cipher_csr_chk #(
  .ADDR_W    (ADDR_W),
  .KEY_WORDS (KEY_WORDS),
  .KEY_W     (KEY_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .core_done   (core_done),
  .core_start  (core_start),
  .unit_en     (unit_en),
  .cfg_mode    (cfg_mode),
  .cfg_chain   (cfg_chain),
  .cfg_dtype   (cfg_dtype),
  .cfg_keysize (cfg_keysize),
  .key_out     (key_out),
  .stat        (stat_w)
);

// File: tb/cipher_csr_tb_top.sv
`timescale 1ns/1ps
module cipher_csr_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         blk_last = 1'b0, core_done = 1'b0, core_busy = 1'b0;
  logic         core_rd_err = 1'b0, core_wr_err = 1'b0;
  logic [255:0] derived_key = '0;
  logic         core_start, unit_en, cfg_keysize, dma_in_en, dma_out_en, irq;
  logic [1:0]   cfg_mode, cfg_dtype, cfg_phase;
  logic [2:0]   cfg_chain;
  logic [3:0]   cfg_pad;
  logic [255:0] key_out;
  logic [127:0] iv_out;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cipher_csr dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .blk_last(blk_last),
    .core_done(core_done), .core_busy(core_busy), .core_rd_err(core_rd_err),
    .core_wr_err(core_wr_err), .derived_key(derived_key), .core_start(core_start),
    .unit_en(unit_en), .cfg_mode(cfg_mode), .cfg_chain(cfg_chain), .cfg_dtype(cfg_dtype),
    .cfg_keysize(cfg_keysize), .cfg_phase(cfg_phase), .cfg_pad(cfg_pad),
    .dma_in_en(dma_in_en), .dma_out_en(dma_out_en), .key_out(key_out),
    .iv_out(iv_out), .irq(irq)
  );

  // {write data, expected control readback}; all with enable 0
  localparam logic [63:0] TBL [8] = '{
    {32'h0000_0006, 32'h0000_0006},   // R2 data format
    {32'h0000_0018, 32'h0000_0018},   // R4 mode 11 with ECB kept
    {32'h0000_0010, 32'h0000_0018},   // R5 11 -> 10 refused
    {32'h0000_0000, 32'h0000_0000},   // R3 disabled write applies
    {32'h0000_0058, 32'h0000_0050},   // R4 mode 11 with chaining 010 -> 10
    {32'h0000_0038, 32'h0000_0038},   // R4 mode 11 with CBC kept
    {32'hFFFF_FFE6, 32'h00F5_7E66},   // R2 clear bits and reserved read 0
    {32'h0000_0000, 32'h0000_0000}    // R2 back to 0
  };

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0]  r;
    logic [255:0] kexp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, r); check("R1 ctrl", r, 0);
    rd(4'd1, r); check("R1 status", r, 0);
    check("R1 irq/start/en", {irq, core_start, unit_en}, 0);
    check("R1 key", key_out, 0);
    check("R1 iv", iv_out, 0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      wr(4'd0, TBL[i][63:32]);
      rd(4'd0, r);
      check($sformatf("R2/R3/R4/R5 table %0d", i), r, TBL[i][31:0]);
    end

    // R10 / R11 keys and IV
    wr(4'd0, 32'h0004_0000);
    kexp = '0;
    for (int i = 0; i < 8; i++) begin
      wr(4'(2 + i), 32'hA000_0000 + 32'(i) * 32'h0101);
      kexp[i*32 +: 32] = 32'hA000_0000 + 32'(i) * 32'h0101;
    end
    check("R10 key_out full", key_out, kexp);
    rd(4'd5, r); check("R10 key word 3 read", r, 32'hA000_0303);
    wr(4'd12, 32'h55AA_55AA);
    check("R10 iv word 2", iv_out[95:64], 32'h55AA_55AA);
    wr(4'd0, 32'h0000_0000);
    check("R11 upper half zero", key_out[255:128], 0);
    check("R11 lower half", key_out[127:0], kexp[127:0]);
    wr(4'd0, 32'h0004_0000);

    // R13 enable start pulse
    wr(4'd0, 32'h0004_0001);
    check("R13 enable", unit_en, 1);
    check("R13 start on enable", core_start, 1);
    @(negedge clk);
    check("R13 start single cycle", core_start, 0);

    // R3 lock while enabled
    wr(4'd0, 32'h0000_0007);
    rd(4'd0, r); check("R3 locked fields", r, 32'h0004_0001);

    // R10 writes dropped while enabled
    wr(4'd2, 32'hDEAD_BEEF);
    check("R10 key drop", key_out[31:0], 32'hA000_0000);
    wr(4'd10, 32'h1234_0000);
    check("R10 iv drop", iv_out[31:0], 0);

    // R13 last word start
    @(negedge clk); blk_last = 1'b1;
    @(negedge clk); blk_last = 1'b0;
    check("R13 start on last word", core_start, 1);
    @(negedge clk);
    check("R13 last-word pulse width", core_start, 0);

    // R7 / R9 done flag and interrupt
    pulse_done();
    rd(4'd1, r); check("R7 done flag", r, 1);
    check("R9 irq masked", irq, 0);
    wr(4'd0, 32'h0004_0201);
    check("R9 done irq", irq, 1);
    wr(4'd0, 32'h0004_0281);
    rd(4'd1, r); check("R8 done clear", r, 0);
    check("R9 irq after clear", irq, 0);

    // errors
    @(negedge clk); core_rd_err = 1'b1;
    @(negedge clk); core_rd_err = 1'b0;
    rd(4'd1, r); check("R7 read error", r, 32'h2);
    check("R9 error masked", irq, 0);
    wr(4'd0, 32'h0004_0601);
    check("R9 error irq", irq, 1);
    @(negedge clk); core_wr_err = 1'b1;
    @(negedge clk); core_wr_err = 1'b0;
    core_busy = 1'b1;
    rd(4'd1, r); check("R7 errors and busy", r, 32'hE);
    core_busy = 1'b0;
    wr(4'd0, 32'h0004_0701);
    rd(4'd1, r); check("R8 error clear", r, 0);
    check("R9 irq after error clear", irq, 0);

    // R8 set beats clear
    @(negedge clk);
    core_done = 1'b1; bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h0004_0681;
    @(negedge clk);
    core_done = 1'b0; bus_wr = 1'b0;
    rd(4'd1, r); check("R8 set wins", r, 1);

    // R3 write that clears enable applies fields
    wr(4'd0, 32'h0000_0010);
    rd(4'd0, r); check("R3 unlock on disable", r, 32'h0000_0010);

    // R12 derived key view
    wr(4'd3, 32'h1234_5678);
    for (int i = 0; i < 8; i++) derived_key[i*32 +: 32] = 32'hC0DE_0000 + 32'(i);
    rd(4'd3, r); check("R12 written key before enable", r, 32'h1234_5678);
    wr(4'd0, 32'h0000_0011);
    rd(4'd3, r); check("R12 written key before done", r, 32'h1234_5678);
    pulse_done();
    rd(4'd3, r); check("R12 derived key after done", r, 32'hC0DE_0001);

    // R6 key preparation self clear
    wr(4'd0, 32'h0000_0080);
    wr(4'd0, 32'h0000_0008);
    wr(4'd0, 32'h0000_0009);
    check("R6 enabled", unit_en, 1);
    pulse_done();
    check("R6 enable cleared", unit_en, 0);
    rd(4'd0, r); check("R6 ctrl after prep", r, 32'h0000_0008);
    rd(4'd1, r); check("R6 done flag", r, 1);

    finish_run();
  end

endmodule